// File: doc/BRIEF.md
# Legacy Region Read/Write Steering Decoder

This block sits on the request path of a memory controller and decides, for every processor memory request below 4 GB, where that request goes. There are three possible targets: system DRAM, the slow legacy I/O path, and the PCI Express enhanced configuration space. The decision depends on the request address and, inside the BIOS shadow area, on whether the request is a read or a write. Because of this, firmware can copy a ROM image into DRAM by reading from the legacy path while writing to DRAM, and then lock the image by sending reads to DRAM and writes to the legacy path.

Firmware programs the block through a small register write port. The port sets one 2-bit attribute per BIOS-area segment, an enable for the hole at 15 MB to 16 MB, and the base, size and enable of the configuration window. Each request is decoded in one registered stage. The cycle after the request strobe, exactly one of the three route flags is high.

Top module: `legacy_steer_decoder`

## Requirements
- R1: While reset is asserted and in the cycle after it, all three route flags are low. Reset clears every register: all attributes become 00, the hole is disabled and the window is disabled.
- R2: A BIOS-area attribute is decoded as follows. 00 sends all accesses to the legacy path. 01 sends reads to DRAM and writes to legacy. 10 sends writes to DRAM and reads to legacy. 11 sends all accesses to DRAM.
- R3: Register select 0 holds the attributes. Field k sits at bits [2k+1:2k]. For k from 0 to 11, field k covers the 16 KB segment starting at 0C0000h + k·4000h. Field 12 covers the whole range 0F0000h–0FFFFFh.
- R4: With the hole bit set (register select 1, bit 0), requests to 0F00000h–0FFFFFFh go to legacy. With the hole bit clear, those requests go to DRAM.
- R5: Register select 2 holds the window settings. Bits [23:4] are the base (physical address bits [39:20]), bits [3:1] are the size code and bit 0 is the enable. Size code 000 gives 256 MB, 110 gives 64 MB and 111 gives 128 MB. Base bits below the window size are ignored. A request inside the naturally aligned window is flagged as configuration space.
- R6: The window is off when its enable bit is clear, or when its size code is one of 001 to 101.
- R7: When a request matches more than one region, the window takes precedence over the BIOS area, which takes precedence over the hole, which takes precedence over DRAM.
- R8: Every request strobe produces exactly one route flag in the following cycle. No flag is raised in a cycle that follows no strobe.
- R9: If a request and a register write arrive in the same cycle, the request is decoded with the register values from before the write. The next request sees the new values.
- R10: A request that matches no region goes to DRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 attributes, 1 hole, 2 window, 3 unused |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| to_dram | output | 1 | Request is steered to DRAM |
| to_legacy | output | 1 | Request is steered to the legacy I/O path |
| to_cfg | output | 1 | Request hits the configuration window |

## Verification
A register update and a request decode can happen in the same cycle. The most visible case is a rewrite of the attribute field for the very segment being accessed, or a move of the window onto the requested address. The bench provokes these collisions on purpose and also lets them occur in a long random stream where writes and requests are interleaved. The reference model judges each collision by decoding the request against the settings it held before applying the same-cycle write.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef enum logic [1:0] {
        ATTR_LEGACY  = 2'b00,
        ATTR_RD_DRAM = 2'b01,
        ATTR_WR_DRAM = 2'b10,
        ATTR_DRAM    = 2'b11
    } seg_attr_t;

    typedef struct packed {
        logic cfg;
        logic legacy;
        logic dram;
    } route_t;

    localparam logic [1:0] SEL_ATTR = 2'd0;
    localparam logic [1:0] SEL_HOLE = 2'd1;
    localparam logic [1:0] SEL_WIN  = 2'd2;

    localparam logic [2:0] SZ_256M = 3'b000;
    localparam logic [2:0] SZ_64M  = 3'b110;
    localparam logic [2:0] SZ_128M = 3'b111;

endpackage

// File: rtl/lsd_cfg_regs.sv
module lsd_cfg_regs
    import lsd_pkg::*;
#(
    parameter int NUM_FIELDS = 13,
    parameter int BASE_W     = 20,
    parameter int DATA_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [2*NUM_FIELDS-1:0] attr_bits,
    output logic                    hole_en,
    output logic [BASE_W-1:0]       win_base,
    output logic [2:0]              win_size,
    output logic                    win_en
);
    localparam int ATTR_W = 2 * NUM_FIELDS;

    typedef struct packed {
        logic [ATTR_W-1:0] attr;
        logic              hole;
        logic [BASE_W-1:0] base;
        logic [2:0]        size;
        logic              en;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_ATTR: regs_d.attr = wr_data[ATTR_W-1:0];
                SEL_HOLE: regs_d.hole = wr_data[0];
                SEL_WIN: begin
                    regs_d.base = wr_data[BASE_W+3:4];
                    regs_d.size = wr_data[3:1];
                    regs_d.en   = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign attr_bits = regs_q.attr;
    assign hole_en   = regs_q.hole;
    assign win_base  = regs_q.base;
    assign win_size  = regs_q.size;
    assign win_en    = regs_q.en;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

endmodule

// File: rtl/lsd_bios_seg.sv
module lsd_bios_seg
    import lsd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SMALL = 12
) (
    input  logic [ADDR_W-15:0]         a_hi,
    input  logic [2*(NUM_SMALL+1)-1:0] attr_bits,
    output logic                       in_bios,
    output seg_attr_t                  seg_attr
);
    localparam int NUM_FIELDS = NUM_SMALL + 1;
    localparam int FLD_W      = $clog2(NUM_FIELDS);

    logic [3:0]       blk;
    logic [FLD_W-1:0] field;

    always_comb begin
        blk     = a_hi[3:0];
        in_bios = (a_hi[ADDR_W-15:6] == '0) && (a_hi[5:4] == 2'b11);
        if (int'(blk) < NUM_SMALL) field = FLD_W'(blk);
        else                       field = FLD_W'(NUM_SMALL);
        seg_attr = seg_attr_t'(attr_bits[2*field +: 2]);
    end

endmodule

// File: rtl/lsd_win_match.sv
module lsd_win_match
    import lsd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-21:0] a_hi,
    input  logic [BASE_W-1:0] win_base,
    input  logic [2:0]        win_size,
    input  logic              win_en,
    output logic              hit
);
    localparam int PAD = BASE_W - (ADDR_W - 20);

    logic [BASE_W-1:0] a_ext, keep_mask;
    logic              size_ok;

    always_comb begin
        a_ext   = {{PAD{1'b0}}, a_hi};
        size_ok = 1'b1;
        case (win_size)
            SZ_256M: keep_mask = {BASE_W{1'b1}} << 8;
            SZ_128M: keep_mask = {BASE_W{1'b1}} << 7;
            SZ_64M:  keep_mask = {BASE_W{1'b1}} << 6;
            default: begin
                keep_mask = '0;
                size_ok   = 1'b0;
            end
        endcase
        hit = win_en && size_ok && (((a_ext ^ win_base) & keep_mask) == '0);
    end

    p_resv_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_en || (win_size inside {3'b001, 3'b010, 3'b011, 3'b100, 3'b101})) |-> !hit);

endmodule

// File: rtl/legacy_steer_decoder.sv
module legacy_steer_decoder
    import lsd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PA_W      = 40,
    parameter int NUM_SMALL = 12,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              to_dram,
    output logic              to_legacy,
    output logic              to_cfg
);
    localparam int BASE_W     = PA_W - 20;
    localparam int NUM_FIELDS = NUM_SMALL + 1;

    logic [2*NUM_FIELDS-1:0] attr_bits;
    logic                    hole_en, win_en, win_hit, in_bios, in_hole;
    logic [BASE_W-1:0]       win_base;
    logic [2:0]              win_size;
    seg_attr_t               seg_attr;
    route_t                  route_d, route_q;

    lsd_cfg_regs #(.NUM_FIELDS(NUM_FIELDS), .BASE_W(BASE_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .attr_bits(attr_bits), .hole_en(hole_en), .win_base(win_base),
        .win_size(win_size), .win_en(win_en)
    );

    lsd_bios_seg #(.ADDR_W(ADDR_W), .NUM_SMALL(NUM_SMALL)) u_seg (
        .a_hi(req_addr[ADDR_W-1:14]), .attr_bits(attr_bits),
        .in_bios(in_bios), .seg_attr(seg_attr)
    );

    lsd_win_match #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_win (
        .clk(clk), .rst_n(rst_n), .a_hi(req_addr[ADDR_W-1:20]), .win_base(win_base),
        .win_size(win_size), .win_en(win_en), .hit(win_hit)
    );

    assign in_hole = (req_addr[ADDR_W-1:24] == '0) && (req_addr[23:20] == 4'hF);

    always_comb begin
        route_d = '0;
        if (req_valid) begin
            if (win_hit) begin
                route_d.cfg = 1'b1;
            end else if (in_bios) begin
                case (seg_attr)
                    ATTR_LEGACY:  route_d.legacy = 1'b1;
                    ATTR_RD_DRAM: begin
                        route_d.dram   = !req_write;
                        route_d.legacy = req_write;
                    end
                    ATTR_WR_DRAM: begin
                        route_d.dram   = req_write;
                        route_d.legacy = !req_write;
                    end
                    default:      route_d.dram = 1'b1;
                endcase
            end else if (hole_en && in_hole) begin
                route_d.legacy = 1'b1;
            end else begin
                route_d.dram = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) route_q <= '0;
        else        route_q <= route_d;
    end

    assign to_dram   = route_q.dram;
    assign to_legacy = route_q.legacy;
    assign to_cfg    = route_q.cfg;

    logic unused_low_addr;
    assign unused_low_addr = ^req_addr[13:0];

    p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($countones({to_cfg, to_legacy, to_dram}) == 1));
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(to_cfg || to_legacy || to_dram));
    p_cfg_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win_hit) |=> to_cfg);
    p_hole_legacy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hole_en && in_hole && !win_hit && !in_bios) |=> to_legacy);
    p_rd_dram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_bios && !win_hit && !req_write && seg_attr == ATTR_RD_DRAM) |=> to_dram);

endmodule

// File: tb/tb_legacy_steer_decoder.sv
`timescale 1ns/1ps
module tb_legacy_steer_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        to_dram, to_legacy, to_cfg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench-side copy of programmed settings
    longint m_attr = 0;
    int     m_hole = 0;
    longint m_base = 0;
    int     m_size = 0;
    int     m_en   = 0;

    always #2 clk = ~clk;

    legacy_steer_decoder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .to_dram(to_dram), .to_legacy(to_legacy), .to_cfg(to_cfg)
    );

    // returns {cfg, legacy, dram}
    function automatic logic [2:0] model(input longint a, input bit w);
        longint sz, b;
        int f, at;
        bit hit;
        sz  = (m_size == 0) ? 64'h1000_0000 : (m_size == 7) ? 64'h0800_0000 :
              (m_size == 6) ? 64'h0400_0000 : 0;
        hit = 0;
        if (m_en != 0 && sz != 0) begin
            b   = (m_base * 64'h10_0000) & ~(sz - 1);
            hit = (a >= b) && (a < b + sz);
        end
        if (hit) return 3'b100;
        if (a >= 64'hC0000 && a <= 64'hFFFFF) begin
            f = int'((a - 64'hC0000) / 64'h4000);
            if (f > 12) f = 12;
            at = int'((m_attr >> (2 * f)) & 3);
            if (at == 3) return 3'b001;
            if (at == 1) return w ? 3'b010 : 3'b001;
            if (at == 2) return w ? 3'b001 : 3'b010;
            return 3'b010;
        end
        if (m_hole != 0 && a >= 64'hF0_0000 && a <= 64'hFF_FFFF) return 3'b010;
        return 3'b001;
    endfunction

    task automatic apply_write(input logic [1:0] s, input logic [31:0] d);
        if (s == 2'd0) m_attr = longint'(d & 32'h03FF_FFFF);
        else if (s == 2'd1) m_hole = int'(d[0]);
        else if (s == 2'd2) begin
            m_base = longint'(d[23:4]);
            m_size = int'(d[3:1]);
            m_en   = int'(d[0]);
        end
    endtask

    task automatic check(input logic [2:0] exp, input string tag, input logic [31:0] a);
        logic [2:0] got;
        got = {to_cfg, to_legacy, to_dram};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h got cfg/leg/dram=%b expected %b", tag, a, got, exp);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input bit w,
                        input bit we, input logic [1:0] ws, input logic [31:0] wd,
                        input string tag);
        logic [2:0] exp;
        req_valid = v; req_addr = a; req_write = w;
        wr_en = we; wr_sel = ws; wr_data = wd;
        exp = v ? model(longint'(a), w) : 3'b000;
        if (we) apply_write(ws, wd);
        @(posedge clk); #1;
        req_valid = 0; wr_en = 0;
        check(exp, tag, a);
    endtask

    task automatic req(input logic [31:0] a, input bit w, input string tag);
        step(1, a, w, 0, 2'd0, 32'h0, tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        step(0, 32'h0, 0, 1, s, d, "R8");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] pat;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1; check(3'b000, "R1", 32'h0);
        req_valid = 1; req_addr = 32'hC0000;
        @(posedge clk); #1;
        check(3'b000, "R1", 32'hC0000);
        req_valid = 0; rst_n = 1;
        req(32'h000C_0000, 0, "R1");       // attr 00 after reset -> legacy
        req(32'h00F0_0000, 0, "R1");       // hole off -> dram
        req(32'h0000_0000, 1, "R10");
        step(0, 32'h0, 0, 0, 2'd0, 32'h0, "R8");

        // R3 / R2: field k gets code k%4
        pat = 0;
        for (int k = 0; k < 13; k++) pat |= (32'(k % 4) << (2 * k));
        wr(2'd0, pat);
        for (int k = 0; k < 12; k++) begin
            req(32'hC0000 + 32'(k) * 32'h4000, 0, "R3");
            req(32'hC0000 + 32'(k) * 32'h4000 + 32'h3FFF, 1, "R3");
        end
        req(32'hF0000, 0, "R3");
        req(32'hFFFFF, 1, "R3");
        req(32'hF8000, 0, "R3");
        // R2: all four codes on field 0
        for (int c = 0; c < 4; c++) begin
            wr(2'd0, 32'(c));
            req(32'hC0000, 0, "R2");
            req(32'hC0000, 1, "R2");
        end
        req(32'hBFFFF, 0, "R10");
        req(32'h100000, 1, "R10");

        // R4: hole
        wr(2'd1, 32'h1);
        req(32'hF00000, 0, "R4");
        req(32'hFFFFFF, 1, "R4");
        req(32'hEFFFFF, 0, "R4");
        req(32'h1000000, 1, "R4");
        wr(2'd1, 32'h0);
        req(32'hF80000, 0, "R4");

        // R5: window sizes, ignored low base bits
        wr(2'd2, {8'h0, 20'hE35, 3'b000, 1'b1});
        req(32'hE000_0000, 0, "R5");
        req(32'hEFFF_FFFF, 1, "R5");
        req(32'hDFFF_FFFF, 0, "R5");
        req(32'hF000_0000, 0, "R5");
        wr(2'd2, {8'h0, 20'h0C0, 3'b111, 1'b1});
        req(32'h0800_0000, 0, "R5");
        req(32'h0FFF_FFFF, 0, "R5");
        req(32'h1000_0000, 0, "R5");
        wr(2'd2, {8'h0, 20'hFC0, 3'b110, 1'b1});
        req(32'hFC00_0000, 1, "R5");
        req(32'hFBFF_FFFF, 1, "R5");
        wr(2'd2, {8'h0, 20'h1F00, 3'b000, 1'b1});   // above 4 GB
        req(32'h0000_0000, 0, "R5");

        // R6: reserved codes and disable
        for (int c = 1; c < 6; c++) begin
            wr(2'd2, {8'h0, 20'h000, 3'(c), 1'b1});
            req(32'h0000_1000, 0, "R6");
        end
        wr(2'd2, {8'h0, 20'h000, 3'b000, 1'b0});
        req(32'h0000_1000, 0, "R6");

        // R7: window over BIOS area and hole
        wr(2'd1, 32'h1);
        wr(2'd0, 32'h03FF_FFFF);
        wr(2'd2, {8'h0, 20'h000, 3'b110, 1'b1});
        req(32'hC4000, 0, "R7");
        req(32'hF00000, 1, "R7");
        wr(2'd2, 32'h0);
        req(32'hC4000, 0, "R7");
        req(32'hF00000, 1, "R7");

        // R9: same-cycle write and request
        step(1, 32'hC0000, 0, 1, 2'd0, 32'h0, "R9");   // old code 11 -> dram
        req(32'hC0000, 0, "R9");                       // new code 00 -> legacy
        step(1, 32'h2000_0000, 0, 1, 2'd2, {8'h0, 20'h200, 3'b000, 1'b1}, "R9");
        req(32'h2000_0000, 0, "R9");
        step(1, 32'hF10000, 1, 1, 2'd1, 32'h0, "R9");
        req(32'hF10000, 1, "R9");

        // random mix, writes colliding with requests
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, d;
            int pick;
            pick = int'($urandom % 4);
            a = (pick == 0) ? (32'hC0000 | ($urandom & 32'h3FFFF)) :
                (pick == 1) ? (32'hF00000 | ($urandom & 32'hFFFFF)) :
                (pick == 2) ? ($urandom & 32'h0FFF_FFFF) : $urandom;
            d = $urandom;
            if (($urandom % 3) == 0) d[23:12] = 12'h0;
            step(($urandom % 4) != 0, a, 1'($urandom), ($urandom % 6) == 0,
                 2'($urandom), d, "R8");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule